// File: doc/BRIEF.md
# Two-Wire Paged Memory Slave

This block is a serial two-wire slave that sits in front of a 256-byte nonvolatile store. The store is organised as 32 pages of 8 bytes. Every access goes through an 8-byte shadow buffer. A write fills the shadow of one page. On a stop condition the whole page is copied back into the array by a timed commit cycle. A read loads the shadow with the page that holds the current pointer, and reloads it each time the pointer moves into a new page. Three bytes at the top of the address map drive wiper-position outputs. A write-protect input blocks every commit.

SCL and SDA are sampled with the system clock through a two-stage synchroniser. All protocol events are found on the synchronised levels. The slave never stretches SCL, so the master alone sets the pace of the transfer. The only data path at the pins is the open-drain SDA line: `sda_oe` high means the slave pulls the line low, and there is no back-pressure beyond the per-byte acknowledge. The external bus is expected to run at least four system clocks per SCL phase.

Top module: `twi_page_mem`

## Requirements
- R1: A start condition (SDA falling while SCL is high) abandons any transfer in progress. Write data staged before that start is discarded without a commit, and the slave then expects a device-address byte. A stop condition (SDA rising while SCL is high) ends the transfer.
- R2: The device-address byte is sent MSB first as 1,0,1,0,0,0, then the strap value, then a read/write bit (1 = read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start. The slave changes `sda_oe` only after an SCL falling edge, a start, a stop or a busy cycle.
- R3: In write mode the byte after the device address is the memory address and is acknowledged. Bits 7..3 select the page and bits 2..0 select the byte within the page.
- R4: Each write data byte is acknowledged and stored at the byte pointer. The pointer then advances within the page and wraps from byte 7 to byte 0. More than 8 bytes therefore overwrite earlier ones.
- R5: A stop after at least one data byte, with `wp_i` low, raises `busy` for WRITE_CYCLES clocks. All 8 shadow bytes are then copied into the array, and array contents and tap outputs change only in the cycle `busy` falls.
- R6: A read starts at the current pointer. That is the last memory address set, advanced past every byte written (within its page) or read since then. Each byte sent advances the pointer by one, across page boundaries and from FFh to 00h. A master NACK ends the read.
- R7: While `busy` is high, every bus event is ignored: no byte is acknowledged and no new commit can start.
- R8: With `wp_i` high at the stop, no commit happens, `busy` stays low and the array is unchanged.
- R9: `tap_a` equals the byte at F8h. `tap_b` and `tap_c` take the bytes at F9h and FAh with bit 7 dropped, and any remaining code above 63h is shown as 63h.
- R10: Bytes FBh to FFh are stored and read back like any other byte, but they never change a tap output.
- R11: After reset the array and shadow hold zero, `busy` is low, `sda_oe` is low and all taps read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or a 0 data bit) |
| addr_strap | input | 1 | Strap bit compared with device-address bit 1 |
| wp_i | input | 1 | Write protect, high blocks commits |
| busy | output | 1 | Commit cycle in progress |
| tap_a | output | 8 | 256-position wiper code from F8h |
| tap_b | output | 7 | 100-position wiper code from F9h |
| tap_c | output | 7 | 100-position wiper code from FAh |

## Verification
Several properties are checked on every cycle. The slave stays off the line while a commit runs, and it never requests a commit while one is in flight or while protection was high. The taps change only in the cycle the commit ends, and `sda_oe` moves only after an SCL fall or a start, stop or busy event. Other behaviour can only be shown by bench scenarios that compare read-back data with a reference model. These cover page wrap on writes, whole-page commit, pointer carry across pages and from FFh to 00h, discarded data after a repeated start, the ignored address during a commit, protection, and tap saturation and reserved bytes.

// File: rtl/twi_pm_pkg.sv
package twi_pm_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int IDX_W      = 3;
  localparam int PAGE_W     = ADDR_W - IDX_W;
  localparam int PAGE_BYTES = 1 << IDX_W;
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int BIT_W      = $clog2(BYTE_W);

  localparam logic [5:0] DEV_TAG_DEF = 6'b101000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_MADDR,
    ST_MADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK
  } slv_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SCL steady high on both samples while SDA moves marks a bus condition
  assign start_ev = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pm_pkg::*;
#(
  parameter logic [5:0] DEV_TAG = DEV_TAG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              strap,
  input  logic              wp,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ld_en,
  output logic [PAGE_W-1:0] ld_page,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              commit_req,
  output logic [PAGE_W-1:0] commit_page,
  output logic              sda_oe
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  slv_state_e        state;
  logic [BIT_W-1:0]  bitcnt;
  logic [BYTE_W-2:0] rxsh;
  logic [BYTE_W-1:0] txsh;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] ptr, ptr_next;
  logic ack_drv, rd_mode, mack_ok, dirty;

  assign rx_byte  = {rxsh, sda_lvl};
  assign ptr_next = ptr + 1'b1;
  assign rd_idx   = ptr[IDX_W-1:0];
  assign sda_oe   = ack_drv | ((state == ST_TX) & ~txsh[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      rxsh        <= '0;
      txsh        <= '0;
      ack_drv     <= 1'b0;
      rd_mode     <= 1'b0;
      mack_ok     <= 1'b0;
      dirty       <= 1'b0;
      ptr         <= '0;
      ld_en       <= 1'b0;
      ld_page     <= '0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
      commit_req  <= 1'b0;
      commit_page <= '0;
    end else begin
      ld_en      <= 1'b0;
      wr_en      <= 1'b0;
      commit_req <= 1'b0;
      if (busy) begin
        state   <= ST_IDLE;
        ack_drv <= 1'b0;
      end else if (start_ev) begin
        state   <= ST_DEV;
        bitcnt  <= '0;
        ack_drv <= 1'b0;
        dirty   <= 1'b0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        ack_drv <= 1'b0;
        dirty   <= 1'b0;
        if (dirty && !wp) begin
          commit_req  <= 1'b1;
          commit_page <= ptr[ADDR_W-1:IDX_W];
        end
      end else begin
        unique case (state)
          ST_DEV, ST_MADDR, ST_WDATA: begin
            if (scl_rise) begin
              rxsh   <= rx_byte[BYTE_W-2:0];
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                if (state == ST_DEV) begin
                  if (rx_byte[BYTE_W-1:1] == {DEV_TAG, strap}) begin
                    rd_mode <= rx_byte[0];
                    state   <= ST_DEV_ACK;
                    if (rx_byte[0]) begin
                      ld_en   <= 1'b1;
                      ld_page <= ptr[ADDR_W-1:IDX_W];
                    end
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_MADDR) begin
                  ptr     <= rx_byte;
                  ld_en   <= 1'b1;
                  ld_page <= rx_byte[ADDR_W-1:IDX_W];
                  state   <= ST_MADDR_ACK;
                end else begin
                  wr_en               <= 1'b1;
                  wr_idx              <= ptr[IDX_W-1:0];
                  wr_data             <= rx_byte;
                  ptr[IDX_W-1:0]      <= ptr[IDX_W-1:0] + 1'b1;
                  dirty               <= 1'b1;
                  state               <= ST_WDATA_ACK;
                end
              end
            end
          end
          ST_DEV_ACK, ST_MADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              if (!ack_drv) begin
                ack_drv <= 1'b1;
              end else begin
                ack_drv <= 1'b0;
                bitcnt  <= '0;
                if (state == ST_DEV_ACK) begin
                  if (rd_mode) begin
                    state <= ST_TX;
                    txsh  <= rd_data;
                  end else begin
                    state <= ST_MADDR;
                  end
                end else begin
                  state <= ST_WDATA;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall) begin
              if (bitcnt == '0) state <= ST_MACK;
              else              txsh  <= {txsh[BYTE_W-2:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_lvl;
              ptr     <= ptr_next;
              if (ptr[IDX_W-1:0] == LAST_IDX) begin
                ld_en   <= 1'b1;
                ld_page <= ptr_next[ADDR_W-1:IDX_W];
              end
            end
            if (scl_fall) begin
              if (mack_ok) begin
                state  <= ST_TX;
                txsh   <= rd_data;
                bitcnt <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the line driver only moves after SCL falls or on a bus/commit event
  assert_sda_moves_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev || busy));

  // R8: a commit request is only raised when protection was low
  assert_commit_needs_wp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> $past(!wp));
endmodule

// File: rtl/page_shadow_mem.sv
module page_shadow_mem
  import twi_pm_pkg::*;
#(
  parameter int                WRITE_CYCLES = 100,
  parameter logic [ADDR_W-1:0] TAP_A_ADDR   = 8'hF8,
  parameter logic [ADDR_W-1:0] TAP_B_ADDR   = 8'hF9,
  parameter logic [ADDR_W-1:0] TAP_C_ADDR   = 8'hFA
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_en,
  input  logic [PAGE_W-1:0]      ld_page,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic                   commit_req,
  input  logic [PAGE_W-1:0]      commit_page,
  output logic [BYTE_W-1:0]      rd_data,
  output logic                   busy,
  output logic [BYTE_W-1:0]      raw_full,
  output logic [1:0][BYTE_W-2:0] raw_lim
);
  localparam int CNT_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

  logic [BYTE_W-1:0] arr    [MEM_BYTES];
  logic [BYTE_W-1:0] shadow [PAGE_BYTES];
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] cpage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) arr[i] <= '0;
      for (int j = 0; j < PAGE_BYTES; j++) shadow[j] <= '0;
      busy  <= 1'b0;
      cnt   <= '0;
      cpage <= '0;
    end else begin
      if (ld_en) begin
        for (int j = 0; j < PAGE_BYTES; j++)
          shadow[j] <= arr[{ld_page, IDX_W'(j)}];
      end else if (wr_en) begin
        shadow[wr_idx] <= wr_data;
      end
      if (commit_req) begin
        busy  <= 1'b1;
        cnt   <= '0;
        cpage <= commit_page;
      end else if (busy) begin
        if (cnt == CNT_LAST) begin
          busy <= 1'b0;
          for (int j = 0; j < PAGE_BYTES; j++)
            arr[{cpage, IDX_W'(j)}] <= shadow[j];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rd_data    = shadow[rd_idx];
  assign raw_full   = arr[TAP_A_ADDR];
  assign raw_lim[0] = arr[TAP_B_ADDR][BYTE_W-2:0];
  assign raw_lim[1] = arr[TAP_C_ADDR][BYTE_W-2:0];

  // R7: no second commit can be requested while one is running
  assert_no_commit_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> !busy);
endmodule

// File: rtl/tap_limit.sv
module tap_limit #(
  parameter int CHANNELS   = 2,
  parameter int CODE_W     = 7,
  parameter int FINE_STEPS = 100
) (
  input  logic [CHANNELS-1:0][CODE_W-1:0] raw,
  output logic [CHANNELS-1:0][CODE_W-1:0] tap
);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(FINE_STEPS - 1);

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    assign tap[g] = (raw[g] > TOP_CODE) ? TOP_CODE : raw[g];
  end
endmodule

// File: rtl/twi_page_mem.sv
module twi_page_mem
  import twi_pm_pkg::*;
#(
  parameter int WRITE_CYCLES = 100,
  parameter int SYNC_STAGES  = 2,
  parameter int FINE_STEPS   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_strap,
  input  logic       wp_i,
  output logic       busy,
  output logic [7:0] tap_a,
  output logic [6:0] tap_b,
  output logic [6:0] tap_c
);
  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic ld_en, wr_en, commit_req;
  logic [PAGE_W-1:0] ld_page, commit_page;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data, raw_full;
  logic [1:0][BYTE_W-2:0] raw_lim, lim_tap;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_slave_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(addr_strap), .wp(wp_i), .busy(busy), .rd_data(rd_data),
    .ld_en(ld_en), .ld_page(ld_page), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .commit_req(commit_req),
    .commit_page(commit_page), .sda_oe(sda_oe)
  );

  page_shadow_mem #(.WRITE_CYCLES(WRITE_CYCLES)) u_mem (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_page(ld_page),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .commit_req(commit_req), .commit_page(commit_page), .rd_data(rd_data),
    .busy(busy), .raw_full(raw_full), .raw_lim(raw_lim)
  );

  tap_limit #(.CHANNELS(2), .CODE_W(BYTE_W-1), .FINE_STEPS(FINE_STEPS)) u_tap (
    .raw(raw_lim), .tap(lim_tap)
  );

  assign tap_a = raw_full;
  assign tap_b = lim_tap[0];
  assign tap_c = lim_tap[1];

  // R7: the slave stays off the line for the whole commit
  assert_quiet_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R5: tap outputs only move in the cycle the commit completes
  assert_taps_move_at_commit_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> ($stable(tap_a) && $stable(tap_b) && $stable(tap_c)));
endmodule

// File: tb/twi_page_mem_test.sv
module twi_page_mem_test;
  localparam int H  = 6;
  localparam int WC = 300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, sda_m, strap, wp;
  logic sda_oe, busy, sda_bus;
  logic [7:0] tap_a;
  logic [6:0] tap_b, tap_c;

  assign sda_bus = sda_m & ~sda_oe;

  twi_page_mem #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .wp_i(wp), .busy(busy),
    .tap_a(tap_a), .tap_b(tap_b), .tap_c(tap_c)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf  [16];
  logic [7:0] mptr;

  function automatic logic [6:0] exp_lim(input logic [7:0] raw);
    return (raw[6:0] > 7'd99) ? 7'd99 : raw[6:0];
  endfunction

  function automatic logic [7:0] dev_byte(input logic rd);
    return {6'b101000, strap, rd};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl = 1'b1;   tick(H);
      scl = 1'b0;
    end
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H/2);
    acked = ~sda_bus;
    tick(H - H/2);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(H);
      scl = 1'b1;   tick(H/2);
      b = {b[6:0], sda_bus};
      tick(H - H/2);
      scl = 1'b0;
    end
    sda_m = ~mack; tick(H);
    scl = 1'b1;    tick(H);
    scl = 1'b0;
  endtask

  task automatic check_taps();
    chk(tap_a == model[8'hF8], "R9 tap_a", tap_a, model[8'hF8]);
    chk(tap_b == exp_lim(model[8'hF9]), "R9 tap_b", tap_b, exp_lim(model[8'hF9]));
    chk(tap_c == exp_lim(model[8'hFA]), "R9 tap_c", tap_c, exp_lim(model[8'hFA]));
  endtask

  task automatic do_write(input logic [7:0] addr, input int n, input logic wp_val, input bit probe);
    logic ack;
    logic [7:0] tmp [8];
    logic [2:0] idx;
    logic [4:0] pg;
    pg  = addr[7:3];
    idx = addr[2:0];
    for (int j = 0; j < 8; j++) tmp[j] = model[{pg, 3'(j)}];
    wp = wp_val;
    bus_start();
    send_byte(dev_byte(1'b0), ack);
    chk(ack == 1'b1, "R2 device address ack", ack, 1);
    send_byte(addr, ack);
    chk(ack == 1'b1, "R3 memory address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack == 1'b1, "R4 data byte ack", ack, 1);
      tmp[idx] = wbuf[i];
      idx = idx + 3'd1;
    end
    bus_stop();
    mptr = {pg, idx};
    tick(4);
    if (n > 0 && !wp_val) begin
      chk(busy == 1'b1, "R5 busy after stop", busy, 1);
      if (probe) begin
        bus_start();
        send_byte(dev_byte(1'b0), ack);
        chk(ack == 1'b0, "R7 address ignored while busy", ack, 0);
        bus_stop();
      end
      for (int k = 0; k < WC + 50 && busy; k++) tick(1);
      chk(busy == 1'b0, "R5 commit finishes", busy, 0);
      for (int j = 0; j < 8; j++) model[{pg, 3'(j)}] = tmp[j];
    end else if (wp_val && n > 0) begin
      chk(busy == 1'b0, "R8 protected write not committed", busy, 0);
    end else begin
      chk(busy == 1'b0, "R5 no commit without data", busy, 0);
    end
    check_taps();
  endtask

  task automatic do_read(input int n, input bit use_addr, input logic [7:0] addr);
    logic ack;
    logic [7:0] b;
    if (use_addr) begin
      bus_start();
      send_byte(dev_byte(1'b0), ack);
      chk(ack == 1'b1, "R2 device address ack", ack, 1);
      send_byte(addr, ack);
      chk(ack == 1'b1, "R3 memory address ack", ack, 1);
      mptr = addr;
    end
    bus_start();
    send_byte(dev_byte(1'b1), ack);
    chk(ack == 1'b1, "R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == model[mptr], "R6 read data", b, model[mptr]);
      mptr = mptr + 8'd1;
    end
    bus_stop();
    tick(H);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    mptr = 8'h00;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 1'b1; wp = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R11 reset state
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    chk(busy == 1'b0, "R11 busy low", busy, 0);
    chk(tap_a == 8'h00 && tap_b == 7'h00 && tap_c == 7'h00, "R11 taps zero",
        {tap_a, 1'b0, tap_b, 1'b0, tap_c}, 0);

    // R2 mismatched strap: no ack, then bus ignored until next start
    bus_start();
    send_byte({6'b101000, ~strap, 1'b0}, ack);
    chk(ack == 1'b0, "R2 mismatch not acked", ack, 0);
    send_byte(8'h00, ack);
    chk(ack == 1'b0, "R2 idle after mismatch", ack, 0);
    bus_stop();

    // single byte write and read back
    wbuf[0] = 8'h3C;
    do_write(8'h10, 1, 1'b0, 1'b0);
    do_read(1, 1'b1, 8'h10);

    // R4 wrap within page with 11 bytes
    for (int i = 0; i < 11; i++) wbuf[i] = 8'(8'h90 + i);
    do_write(8'h25, 11, 1'b0, 1'b0);
    do_read(8, 1'b1, 8'h20);

    // R8 protected write
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hA5;
    do_write(8'h40, 3, 1'b1, 1'b0);
    do_read(3, 1'b1, 8'h40);

    // R7 address during commit ignored
    wbuf[0] = 8'h77;
    do_write(8'h50, 1, 1'b0, 1'b1);
    do_read(1, 1'b1, 8'h50);

    // R1 repeated start discards staged data
    wp = 1'b0;
    bus_start();
    send_byte(dev_byte(1'b0), ack);
    send_byte(8'h60, ack);
    send_byte(8'hEE, ack);
    bus_start();
    send_byte(dev_byte(1'b0), ack);
    chk(ack == 1'b1, "R1 restart accepts new address", ack, 1);
    bus_stop();
    tick(4);
    chk(busy == 1'b0, "R1 no commit after restart", busy, 0);
    do_read(2, 1'b1, 8'h60);

    // R9 taps: F8 full, F9 MSB dropped and saturated, FA in range
    wbuf[0] = 8'hC3; wbuf[1] = 8'hE4; wbuf[2] = 8'h2A;
    do_write(8'hF8, 3, 1'b0, 1'b0);
    chk(tap_b == 7'd99, "R9 saturation to 63h", tap_b, 99);
    chk(tap_c == 7'h2A, "R9 in-range code", tap_c, 8'h2A);

    // R10 reserved bytes stored without tap effect
    for (int i = 0; i < 5; i++) wbuf[i] = 8'(8'h11 * (i + 1));
    do_write(8'hFB, 5, 1'b0, 1'b0);
    chk(tap_a == 8'hC3, "R10 tap_a unchanged", tap_a, 8'hC3);
    do_read(5, 1'b1, 8'hFB);

    // R6 read crossing a page and FFh to 00h
    do_read(6, 1'b1, 8'hFD);
    do_read(3, 1'b1, 8'h26);

    // constrained random writes and reads
    for (int t = 0; t < 18; t++) begin
      logic [7:0] a;
      int n;
      logic wpv;
      a   = ($urandom_range(0, 2) == 0) ? {5'h1F, 3'($urandom)} : 8'($urandom);
      n   = $urandom_range(0, 10);
      wpv = ($urandom_range(0, 4) == 0);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, wpv, 1'b0);
      // R6 read continues from the current pointer
      if (t % 3 == 0) do_read($urandom_range(1, 4), 1'b0, 8'h00);
      else            do_read($urandom_range(1, 6), 1'b1, 8'($urandom));
    end

    // whole-array read back with wrap
    do_read(257, 1'b1, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule